// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block tracks loads that a schedule has moved ahead of earlier stores. When such an early load issues, its memory address and destination register tag are written into a small fully associative table. Every later store broadcasts its address. All live entries compare against it at once, and any entry in the same memory word is killed. When the program reaches the point where the load would first have run, it issues a check on the destination tag. The table answers either "still good", so the early value may be used, or "fixup", so recovery code must re-execute the load.

A tag that has no live entry gives the same fixup answer as a tag whose entry was killed. Because of this, dropping an entry is always safe. Replacement on a full table and the flush input both rely on that. The check answer comes back one cycle after the request.

Top module: `spec_ld_table`

## Requirements
- R1: After reset, or in the cycle after `flush` is sampled high, every entry is dead and any check answers fixup. `chk_done` is low while reset is held.
- R2: After an insert, a check on the same tag answers ok (`chk_ok`=1, `chk_fixup`=0) if no conflicting store came in between. The answer appears in the cycle after `chk_valid`.
- R3: A store kills an entry whose address agrees with the store address in all bits above the low `OFFS_W` (byte offset) bits. A store to a different word leaves the entry live.
- R4: A check on a tag that has no live entry answers fixup.
- R5: An insert with a tag that already has a live entry overwrites that entry in place. After that, only the new address conflicts.
- R6: Insert placement works as follows. If the tag already has a live entry, that entry is used. Otherwise the lowest-numbered dead slot is used. If all slots are live, the slot at a round-robin pointer is used. The pointer starts at slot 0 after reset or flush and advances by one on each eviction. A load that has been evicted then fails its check.
- R7: When an insert and a store to the same word arrive in the same cycle, the insert takes effect last, so the entry stays live.
- R8: A check that answers ok with `chk_clear`=1 kills the entry. With `chk_clear`=0 the entry stays live.
- R9: A check sees the table as it was before any store or insert in the same cycle.
- R10: `chk_done` is high exactly in the cycle after `chk_valid`. While `chk_done` is high, exactly one of `chk_ok` and `chk_fixup` is high. Both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request from an early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| ins_tag | input | TAG_W | Destination register tag of the early load |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W | Register tag to check |
| chk_clear | input | 1 | Kill the entry when the check answers ok |
| flush | input | 1 | Kill every entry and reset the replacement pointer |
| chk_done | output | 1 | Check answer valid, one cycle after the request |
| chk_ok | output | 1 | The early load is still usable |
| chk_fixup | output | 1 | Recovery code must run |

## Verification
A corrupted live bit, address or tag is only visible at the ports through a check answer. It shows up one cycle after the first check on the affected tag: an entry that is wrongly alive answers ok after a conflicting store, and an entry that is wrongly dead answers fixup early. A wrong replacement pointer stays hidden until the table fills. It then shows as the wrong one of the oldest tags failing its check. For that reason the tests fill the table completely and check the evicted tags and their neighbours directly.

// File: rtl/sltab_pkg.sv
package sltab_pkg;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_TAG_W   = 7;
    localparam int unsigned DEF_OFFS_W  = 3;

    // how the insert slot was chosen
    typedef enum logic [1:0] {
        SLOT_REUSE = 2'd0,
        SLOT_FREE  = 2'd1,
        SLOT_EVICT = 2'd2
    } slot_src_e;

    // registered check answer
    typedef struct packed {
        logic done;
        logic ok;
    } chk_res_t;
endpackage

// File: rtl/sltab_match.sv
module sltab_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TAG_W   = 7,
    parameter int unsigned OFFS_W  = 3
) (
    input  logic [ENTRIES-1:0]             vld_q,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q,
    input  logic [ADDR_W-1:0]              st_addr,
    input  logic [TAG_W-1:0]               ins_tag,
    input  logic [TAG_W-1:0]               chk_tag,
    output logic [ENTRIES-1:0]             st_hit,
    output logic [ENTRIES-1:0]             ins_hit,
    output logic [ENTRIES-1:0]             chk_hit
);
    // the byte-offset bits take no part in the compare
    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << OFFS_W) - ADDR_W'(1));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign st_hit[i]  = vld_q[i] && (((addr_q[i] ^ st_addr) & WORD_MASK) == '0);
        assign ins_hit[i] = vld_q[i] && (tag_q[i] == ins_tag);
        assign chk_hit[i] = vld_q[i] && (tag_q[i] == chk_tag);
    end
endmodule

// File: rtl/sltab_alloc.sv
module sltab_alloc
    import sltab_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld_q,
    input  logic [ENTRIES-1:0] tag_hit,
    input  logic [IDX_W-1:0]   rr_q,
    output logic [IDX_W-1:0]   slot,
    output slot_src_e          src
);
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tag_hit[i]) hit_idx  = IDX_W'(i);
            if (!vld_q[i])  free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|tag_hit) begin
            slot = hit_idx;
            src  = SLOT_REUSE;
        end else if (!(&vld_q)) begin
            slot = free_idx;
            src  = SLOT_FREE;
        end else begin
            slot = rr_q;
            src  = SLOT_EVICT;
        end
    end
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
    import sltab_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned TAG_W   = DEF_TAG_W,
    parameter int unsigned OFFS_W  = DEF_OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    input  logic              flush,
    output logic              chk_done,
    output logic              chk_ok,
    output logic              chk_fixup
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] RR_LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]             vld_q, vld_d;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]               rr_q, rr_d;
    chk_res_t                       res_q, res_d;

    logic [ENTRIES-1:0] st_hit, ins_hit, chk_hit;
    logic [IDX_W-1:0]   slot;
    slot_src_e          src;

    sltab_match #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .OFFS_W(OFFS_W)
    ) u_match (
        .vld_q   (vld_q),
        .addr_q  (addr_q),
        .tag_q   (tag_q),
        .st_addr (st_addr),
        .ins_tag (ins_tag),
        .chk_tag (chk_tag),
        .st_hit  (st_hit),
        .ins_hit (ins_hit),
        .chk_hit (chk_hit)
    );

    sltab_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .vld_q   (vld_q),
        .tag_hit (ins_hit),
        .rr_q    (rr_q),
        .slot    (slot),
        .src     (src)
    );

    // update order: check-clear, store kill, insert, flush overrides all
    always_comb begin
        vld_d = vld_q;
        if (chk_valid && chk_clear) vld_d = vld_d & ~chk_hit;
        if (st_valid)               vld_d = vld_d & ~st_hit;
        if (ins_valid)              vld_d[slot] = 1'b1;
        if (flush)                  vld_d = '0;
    end

    always_comb begin
        rr_d = rr_q;
        if (flush) begin
            rr_d = '0;
        end else if (ins_valid && (src == SLOT_EVICT)) begin
            rr_d = (rr_q == RR_LAST) ? '0 : rr_q + IDX_W'(1);
        end
    end

    // the check reads the state held at the start of the cycle
    always_comb begin
        res_d.done = chk_valid;
        res_d.ok   = chk_valid && (|chk_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rr_q  <= '0;
            res_q <= '0;
        end else begin
            vld_q <= vld_d;
            rr_q  <= rr_d;
            res_q <= res_d;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_valid) begin
            addr_q[slot] <= ins_addr;
            tag_q[slot]  <= ins_tag;
        end
    end

    assign chk_done  = res_q.done;
    assign chk_ok    = res_q.ok;
    assign chk_fixup = res_q.done & ~res_q.ok;
endmodule

// File: rtl/sltab_checker.sv
module sltab_checker #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TAG_W   = 7,
    parameter int unsigned OFFS_W  = 3
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             ins_valid,
    input logic [ADDR_W-1:0]                ins_addr,
    input logic [TAG_W-1:0]                 ins_tag,
    input logic                             st_valid,
    input logic [ADDR_W-1:0]                st_addr,
    input logic                             chk_valid,
    input logic                             flush,
    input logic                             chk_done,
    input logic                             chk_ok,
    input logic                             chk_fixup,
    input logic [ENTRIES-1:0]               vld_q,
    input logic [ENTRIES-1:0][ADDR_W-1:0]   addr_q,
    input logic [ENTRIES-1:0][TAG_W-1:0]    tag_q
);
    localparam logic [ADDR_W-1:0] WMASK = ~((ADDR_W'(1) << OFFS_W) - ADDR_W'(1));

    logic              prev_ins, prev_st, prev_flush, prev_empty_chk;
    logic [TAG_W-1:0]  prev_tag;
    logic [ADDR_W-1:0] prev_word;
    logic              tag_live, word_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ins       <= 1'b0;
            prev_st        <= 1'b0;
            prev_flush     <= 1'b0;
            prev_empty_chk <= 1'b0;
            prev_tag       <= '0;
            prev_word      <= '0;
        end else begin
            prev_ins       <= ins_valid && !flush;
            prev_st        <= st_valid &&
                              !(ins_valid && (((ins_addr ^ st_addr) & WMASK) == '0));
            prev_flush     <= flush;
            prev_empty_chk <= chk_valid && (vld_q == '0);
            prev_tag       <= ins_tag;
            prev_word      <= st_addr & WMASK;
        end
    end

    always_comb begin
        tag_live  = 1'b0;
        word_live = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_q[i] && (tag_q[i] == prev_tag))               tag_live  = 1'b1;
            if (vld_q[i] && ((addr_q[i] & WMASK) == prev_word))   word_live = 1'b1;
        end
    end

    assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_done);
    assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !chk_done);
    assert_one_answer_R10: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (chk_ok ^ chk_fixup));
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !chk_done |-> (!chk_ok && !chk_fixup));
    assert_flush_empties_R1: assert property (@(posedge clk) disable iff (rst)
        prev_flush |-> (vld_q == '0));
    assert_insert_live_R2: assert property (@(posedge clk) disable iff (rst)
        prev_ins |-> tag_live);
    assert_store_kills_R3: assert property (@(posedge clk) disable iff (rst)
        prev_st |-> !word_live);
    assert_empty_fixup_R4: assert property (@(posedge clk) disable iff (rst)
        prev_empty_chk |-> chk_fixup);
endmodule

bind spec_ld_table sltab_checker #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .OFFS_W(OFFS_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_addr  (ins_addr),
    .ins_tag   (ins_tag),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .chk_valid (chk_valid),
    .flush     (flush),
    .chk_done  (chk_done),
    .chk_ok    (chk_ok),
    .chk_fixup (chk_fixup),
    .vld_q     (vld_q),
    .addr_q    (addr_q),
    .tag_q     (tag_q)
);

// File: tb/spec_ld_table_tb.sv
`timescale 1ns/1ps
module spec_ld_table_tb;
    localparam int E  = 8;
    localparam int AW = 32;
    localparam int TW = 7;
    localparam int OW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_valid, st_valid, chk_valid, chk_clear, flush;
    logic [AW-1:0] ins_addr, st_addr;
    logic [TW-1:0] ins_tag, chk_tag;
    logic          chk_done, chk_ok, chk_fixup;

    int checks = 0;
    int errors = 0;

    bit    exp_q[$];
    string req_q[$];

    // independent model of the table contents
    bit          m_vld[E];
    bit [AW-1:0] m_addr[E];
    bit [TW-1:0] m_tag[E];
    int          m_rr;

    always #4 clk = ~clk;

    spec_ld_table #(.ENTRIES(E), .ADDR_W(AW), .TAG_W(TW), .OFFS_W(OW)) u_dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_tag(ins_tag),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
        .flush(flush),
        .chk_done(chk_done), .chk_ok(chk_ok), .chk_fixup(chk_fixup)
    );

    function automatic bit same_word(bit [AW-1:0] a, bit [AW-1:0] b);
        return (a >> OW) == (b >> OW);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: compares answers against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && chk_done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected answer ok=%0b, expected no answer", chk_ok);
            end else begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (chk_ok !== e || chk_fixup !== !e) begin
                    errors++;
                    $display("FAIL %s: ok=%0b fixup=%0b, expected ok=%0b fixup=%0b",
                             r, chk_ok, chk_fixup, e, !e);
                end
            end
        end
    end

    // driver: one cycle of stimulus, expected answer pushed before the model updates
    task automatic step(bit iv, bit [AW-1:0] ia, bit [TW-1:0] it,
                        bit sv, bit [AW-1:0] sa,
                        bit cv, bit [TW-1:0] ct, bit cc, bit fl, string req);
        ins_valid = iv; ins_addr = ia; ins_tag = it;
        st_valid = sv; st_addr = sa;
        chk_valid = cv; chk_tag = ct; chk_clear = cc; flush = fl;
        if (cv) begin
            bit hit = 0;
            int hi = 0;
            for (int i = 0; i < E; i++)
                if (m_vld[i] && m_tag[i] == ct) begin hit = 1; hi = i; end
            exp_q.push_back(hit);
            req_q.push_back(req);
            if (hit && cc) m_vld[hi] = 0;
        end
        if (sv)
            for (int i = 0; i < E; i++)
                if (m_vld[i] && same_word(m_addr[i], sa)) m_vld[i] = 0;
        if (iv) begin
            int s = -1;
            for (int i = 0; i < E; i++)
                if (s < 0 && m_vld[i] && m_tag[i] == it) s = i;
            for (int i = 0; i < E; i++)
                if (s < 0 && !m_vld[i]) s = i;
            if (s < 0) begin
                s = m_rr;
                m_rr = (m_rr + 1) % E;
            end
            m_vld[s] = 1; m_addr[s] = ia; m_tag[s] = it;
        end
        if (fl) begin
            for (int i = 0; i < E; i++) m_vld[i] = 0;
            m_rr = 0;
        end
        @(negedge clk);
    endtask

    task automatic ins(bit [AW-1:0] a, bit [TW-1:0] t);
        step(1, a, t, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic st(bit [AW-1:0] a);
        step(0, 0, 0, 1, a, 0, 0, 0, 0, "");
    endtask
    task automatic chk(bit [TW-1:0] t, bit cc, string req);
        step(0, 0, 0, 0, 0, 1, t, cc, 0, req);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < E; i++) m_vld[i] = 0;
        m_rr = 0;
        rst = 1;
        ins_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0; flush = 0;
        ins_addr = 0; st_addr = 0; ins_tag = 0; chk_tag = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (chk_done !== 1'b0) begin
            errors++;
            $display("FAIL R1: chk_done=%0b during reset, expected 0", chk_done);
        end
        rst = 0;

        chk(7'd5, 0, "R1");                  // empty after reset
        ins(32'h100, 7'd1);
        chk(7'd1, 0, "R2");                  // live
        chk(7'd9, 0, "R4");                  // never inserted
        st(32'h104);                         // same word
        chk(7'd1, 0, "R3");
        ins(32'h200, 7'd2);
        st(32'h208);                         // next word
        chk(7'd2, 0, "R3");
        ins(32'h300, 7'd3);
        ins(32'h400, 7'd3);                  // replace
        st(32'h300);
        chk(7'd3, 0, "R5");
        st(32'h400);
        chk(7'd3, 0, "R5");
        step(1, 32'h500, 7'd4, 1, 32'h500, 0, 0, 0, 0, "");
        chk(7'd4, 0, "R7");
        ins(32'h600, 7'd5);
        chk(7'd5, 0, "R8");
        chk(7'd5, 1, "R8");
        chk(7'd5, 0, "R8");
        ins(32'h700, 7'd6);
        step(0, 0, 0, 1, 32'h700, 1, 7'd6, 0, 0, "R9");
        chk(7'd6, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "");  // flush
        chk(7'd2, 0, "R1");
        chk(7'd4, 0, "R1");
        for (int i = 0; i < E; i++) ins(32'h1000 + 32'(i) * 32'h10, 7'(10 + i));
        chk(7'd10, 0, "R6");
        ins(32'h2000, 7'd18);                 // evicts slot 0
        chk(7'd10, 0, "R6");
        chk(7'd11, 0, "R6");
        chk(7'd18, 0, "R6");
        ins(32'h2010, 7'd19);                 // evicts slot 1
        chk(7'd11, 0, "R6");
        chk(7'd12, 0, "R6");
        chk(7'd19, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d answers missing, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule